// File: doc/BRIEF.md
# Wake-Up Power-On Sequencer

This block is the power-control state machine of a battery-backed clock device. It starts a system power-up in two cases: an alarm wake-up event, or an external kickstart pin held low for long enough. Either case sets a cause flag and drives an open-drain power-enable output. The block then opens a power-on window of a fixed number of seconds and waits for the main supply to be reported valid.

If the supply comes up inside the window, the power-enable output stays driven and an open-drain interrupt output goes active. The hardware also clears a power-active enable bit. From then on, power is held for as long as software leaves that bit at 0. If the window expires first, power-enable is quietly released and the interrupt is never driven. The cause flag stays set, so a later boot can see why the earlier attempt was made.

All second counting uses a once-per-second tick. The count only advances while the oscillator is enabled and the countdown chain is not held in reset. Both open-drain outputs are modelled as output enables: 1 means pull low, 0 means high impedance.

Top module: `wkup_pwr_seq`

## Requirements
- R1: When idle, a one-cycle `wake_evt` pulse sets `wf` and drives `pwr_oe` to 1 from the next cycle.
- R2: A valid kickstart sets `kf` and drives `pwr_oe` to 1 in the cycle after the qualifying tick, when the sequencer is idle.
- R3: If `vcc_ok` stays 0 for TIMEOUT_SEC qualified ticks after the window opens, `pwr_oe` returns to 0 after the last of those ticks, and `irq_oe` stays 0.
- R4: A failed attempt leaves its cause flag (`wf` or `kf`) at 1 until software pulses the matching clear input.
- R5: `vcc_ok` high inside the window keeps `pwr_oe` at 1 and sets `irq_oe` to 1 in the next cycle. This includes the cycle of the final qualified tick, where supply-valid wins over the timeout.
- R6: Reset leaves `pab` at 1. Success clears `pab` to 0, and `pwr_oe` stays 1 while `pab` is 0. A software write of 1 to `pab` releases `pwr_oe` one cycle after `pab` reads 1, and the block returns to idle.
- R7: `ks_n` counts as a kickstart only after it has been low continuously for KS_MIN_SEC qualified ticks. Shorter pulses have no effect. A pin held low fires only once.
- R8: Ticks are qualified only while `osc_en` is 1 and `chain_rst` is 0. Otherwise both the window counter and the kickstart counter hold their values.
- R9: A wake-up or kickstart arriving while a sequence is active sets its flag but does not restart the window.
- R10: `irq_oe` returns to 0 one cycle after both `wf` and `kf` read 0.
- R11: After reset, `pwr_oe`, `irq_oe`, `wf` and `kf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wake_evt | input | 1 | Alarm wake-up event pulse |
| ks_n | input | 1 | Kickstart pin, active low, synchronous to clk |
| vcc_ok | input | 1 | Main supply above battery and power-fail levels |
| osc_en | input | 1 | Oscillator enabled |
| chain_rst | input | 1 | Countdown chain held in reset |
| pab_wr | input | 1 | Write strobe for the power-active enable bit |
| pab_wdata | input | 1 | Value written to the power-active enable bit |
| wf_clr | input | 1 | Software clear of the wake-up flag |
| kf_clr | input | 1 | Software clear of the kickstart flag |
| pwr_oe | output | 1 | Power-enable pull-down active (1 = drive low) |
| irq_oe | output | 1 | Interrupt pull-down active (1 = drive low) |
| wf | output | 1 | Wake-up cause flag |
| kf | output | 1 | Kickstart cause flag |
| pab | output | 1 | Power-active enable bit |

## Verification
The main sequence is tried in four ways. A supply that arrives early separates the success path from the timeout path. A supply that arrives on exactly the expiring tick checks that supply-valid wins over the timeout. A supply that never arrives shows that power is released while the cause flag is kept. A run with the oscillator stopped and then the chain held in reset shows that the window freezes rather than expiring.

Kickstart is tried in two ways. A pulse one second too short shows the width rule. A pin held past expiry shows that it fires only once. A repeated wake-up during an open window tells a restarted timeout apart from an ignored one.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_ON   = 2'd2
  } seq_state_t;

  localparam int FLAG_WAKE = 0;
  localparam int FLAG_KICK = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/wkup_rst_sync.sv
module wkup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wkup_sec_cnt.sv
module wkup_sec_cnt #(
  parameter int LIMIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       cnt_en,
  output logic [$clog2(LIMIT+1)-1:0] cnt,
  output logic                       hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] FULL = W'(LIMIT);

  logic [W-1:0] cnt_d;

  // saturating count of qualified seconds; clear has priority
  always_comb begin
    cnt_d = cnt;
    if (clr)                        cnt_d = '0;
    else if (cnt_en && cnt != FULL) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // pulses once, on the tick that completes the interval
  assign hit = cnt_en && !clr && (cnt == LAST);
endmodule

// File: rtl/wkup_flag_bank.sv
module wkup_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set and a clear in the same cycle leave the flag set
    always_comb q_d[i] = set[i] | (q[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q_d[i];
    end
  end
endmodule

// File: rtl/wkup_pwr_seq.sv
module wkup_pwr_seq
  import wkup_pkg::*;
#(
  parameter int TIMEOUT_SEC = 2,
  parameter int KS_MIN_SEC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic wake_evt,
  input  logic ks_n,
  input  logic vcc_ok,
  input  logic osc_en,
  input  logic chain_rst,
  input  logic pab_wr,
  input  logic pab_wdata,
  input  logic wf_clr,
  input  logic kf_clr,
  output logic pwr_oe,
  output logic irq_oe,
  output logic wf,
  output logic kf,
  output logic pab
);
  localparam int TO_W = $clog2(TIMEOUT_SEC + 1);
  localparam int KS_W = $clog2(KS_MIN_SEC + 1);

  logic           rst_sync_n;
  seq_state_t     state_q, state_d;
  logic           tick_ok;
  logic           ks_fire, to_hit;
  logic [TO_W-1:0] to_cnt;
  logic [KS_W-1:0] ks_cnt;
  logic           start, success;
  logic           pab_q, pab_d;
  logic           irq_q, irq_d;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  wkup_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // a second counts only while the divider chain is running
  assign tick_ok = sec_tick & osc_en & ~chain_rst;

  wkup_sec_cnt #(.LIMIT(KS_MIN_SEC)) u_ks_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(ks_n), .cnt_en(~ks_n & tick_ok),
    .cnt(ks_cnt), .hit(ks_fire)
  );

  assign start   = (state_q == SEQ_IDLE) && (wake_evt || ks_fire);
  assign success = (state_q == SEQ_WAIT) && vcc_ok;

  wkup_sec_cnt #(.LIMIT(TIMEOUT_SEC)) u_to_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(start), .cnt_en((state_q == SEQ_WAIT) & tick_ok),
    .cnt(to_cnt), .hit(to_hit)
  );

  assign flag_set[FLAG_WAKE] = wake_evt;
  assign flag_set[FLAG_KICK] = ks_fire;
  assign flag_clr[FLAG_WAKE] = wf_clr;
  assign flag_clr[FLAG_KICK] = kf_clr;

  wkup_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .set(flag_set), .clr(flag_clr), .q(flag_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_WAIT;
      SEQ_WAIT: begin
        if (vcc_ok)      state_d = SEQ_ON;
        else if (to_hit) state_d = SEQ_IDLE;
      end
      SEQ_ON:   if (pab_q) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    pab_d = pab_q;
    if (success)     pab_d = 1'b0;
    else if (pab_wr) pab_d = pab_wdata;
  end

  always_comb begin
    if (success) irq_d = 1'b1;
    else         irq_d = irq_q & (flag_q[FLAG_WAKE] | flag_q[FLAG_KICK]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SEQ_IDLE;
      pab_q   <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pab_q   <= pab_d;
      irq_q   <= irq_d;
    end
  end

  assign pwr_oe = (state_q != SEQ_IDLE);
  assign irq_oe = irq_q;
  assign wf     = flag_q[FLAG_WAKE];
  assign kf     = flag_q[FLAG_KICK];
  assign pab    = pab_q;
endmodule

// File: rtl/wkup_pwr_seq_chk.sv
module wkup_pwr_seq_chk
  import wkup_pkg::*;
#(
  parameter int TO_W = 2
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            wake_evt,
  input logic            vcc_ok,
  input logic            osc_en,
  input logic            chain_rst,
  input logic            pwr_oe,
  input logic            irq_oe,
  input logic            wf,
  input logic            pab,
  input seq_state_t      state_q,
  input logic [TO_W-1:0] to_cnt,
  input logic            to_hit
);
  a_r1_wake_starts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == SEQ_IDLE && wake_evt) |=> (pwr_oe && wf));

  a_r3_fail_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == SEQ_WAIT && to_hit && !vcc_ok) |=> (!pwr_oe && !irq_oe));

  a_r5_irq_on_success: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_oe) |-> (pwr_oe && !pab));

  a_r6_hold_while_pab_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == SEQ_ON && !pab) |=> pwr_oe);

  a_r8_window_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == SEQ_WAIT && (!osc_en || chain_rst)) |=> $stable(to_cnt));
endmodule

bind wkup_pwr_seq wkup_pwr_seq_chk #(.TO_W(TO_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wake_evt(wake_evt), .vcc_ok(vcc_ok),
  .osc_en(osc_en), .chain_rst(chain_rst), .pwr_oe(pwr_oe), .irq_oe(irq_oe),
  .wf(wf), .pab(pab), .state_q(state_q), .to_cnt(to_cnt), .to_hit(to_hit)
);

// File: tb/wkup_pwr_seq_bench.sv
module wkup_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, sec_tick, wake_evt, ks_n, vcc_ok, osc_en, chain_rst;
  logic pab_wr, pab_wdata, wf_clr, kf_clr;
  logic pwr_oe, irq_oe, wf, kf, pab;
  int checks, failures, cycles;

  wkup_pwr_seq #(.TIMEOUT_SEC(2), .KS_MIN_SEC(2)) u_wkup_pwr_seq (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wake_evt(wake_evt),
    .ks_n(ks_n), .vcc_ok(vcc_ok), .osc_en(osc_en), .chain_rst(chain_rst),
    .pab_wr(pab_wr), .pab_wdata(pab_wdata), .wf_clr(wf_clr), .kf_clr(kf_clr),
    .pwr_oe(pwr_oe), .irq_oe(irq_oe), .wf(wf), .kf(kf), .pab(pab)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wake_pulse();
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic clear_flags();
    wf_clr = 1'b1; kf_clr = 1'b1; @(negedge clk);
    wf_clr = 1'b0; kf_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", pwr_oe, 1'b0, "pwr_oe after reset");
    chk("R11", irq_oe, 1'b0, "irq_oe after reset");
    chk("R11", wf, 1'b0, "wf after reset");
    chk("R11", kf, 1'b0, "kf after reset");
    chk("R6", pab, 1'b1, "pab after reset");
  endtask

  task automatic t_wake_success();
    wake_pulse();
    chk("R1", pwr_oe, 1'b1, "pwr_oe after wake");
    chk("R1", wf, 1'b1, "wf after wake");
    tick(1);
    vcc_ok = 1'b1; @(negedge clk);
    chk("R5", pwr_oe, 1'b1, "pwr_oe on success");
    chk("R5", irq_oe, 1'b1, "irq_oe on success");
    chk("R6", pab, 1'b0, "pab cleared on success");
    tick(5);
    chk("R6", pwr_oe, 1'b1, "pwr_oe held while pab low");
    wf_clr = 1'b1; @(negedge clk); wf_clr = 1'b0; @(negedge clk);
    chk("R10", irq_oe, 1'b0, "irq_oe after flags cleared");
    pab_wr = 1'b1; pab_wdata = 1'b1; @(negedge clk); pab_wr = 1'b0;
    chk("R6", pwr_oe, 1'b1, "pwr_oe in cycle pab reads 1");
    @(negedge clk);
    chk("R6", pwr_oe, 1'b0, "pwr_oe released after pab write");
    vcc_ok = 1'b0;
  endtask

  task automatic t_wake_fail();
    clear_flags();
    wake_pulse();
    tick(1);
    chk("R3", pwr_oe, 1'b1, "pwr_oe before expiry");
    tick(1);
    chk("R3", pwr_oe, 1'b0, "pwr_oe after expiry");
    chk("R3", irq_oe, 1'b0, "irq_oe after failure");
    idle(3);
    chk("R4", wf, 1'b1, "wf kept after failure");
    clear_flags();
    chk("R4", wf, 1'b0, "wf cleared by software");
  endtask

  task automatic t_edge_success();
    wake_pulse();
    tick(1);
    sec_tick = 1'b1; vcc_ok = 1'b1; @(negedge clk); sec_tick = 1'b0;
    chk("R5", pwr_oe, 1'b1, "pwr_oe when supply meets last tick");
    chk("R5", irq_oe, 1'b1, "irq_oe when supply meets last tick");
    pab_wr = 1'b1; pab_wdata = 1'b1; @(negedge clk); pab_wr = 1'b0;
    vcc_ok = 1'b0; idle(2);
    clear_flags();
  endtask

  task automatic t_freeze();
    wake_pulse();
    osc_en = 1'b0; tick(5);
    chk("R8", pwr_oe, 1'b1, "pwr_oe with oscillator off");
    osc_en = 1'b1; chain_rst = 1'b1; tick(3);
    chk("R8", pwr_oe, 1'b1, "pwr_oe with chain in reset");
    chain_rst = 1'b0; tick(1);
    chk("R8", pwr_oe, 1'b1, "pwr_oe one tick after resume");
    tick(1);
    chk("R8", pwr_oe, 1'b0, "pwr_oe two ticks after resume");
    clear_flags();
  endtask

  task automatic t_kick();
    ks_n = 1'b0; tick(1); ks_n = 1'b1; tick(2);
    chk("R7", kf, 1'b0, "kf after short pulse");
    chk("R7", pwr_oe, 1'b0, "pwr_oe after short pulse");
    ks_n = 1'b0; tick(1);
    chk("R7", kf, 1'b0, "kf after one low second");
    tick(1);
    chk("R2", kf, 1'b1, "kf after valid kickstart");
    chk("R2", pwr_oe, 1'b1, "pwr_oe after valid kickstart");
    tick(2);
    chk("R3", pwr_oe, 1'b0, "pwr_oe after kickstart timeout");
    tick(3);
    chk("R7", pwr_oe, 1'b0, "no refire while held low");
    ks_n = 1'b1; @(negedge clk);
    chk("R4", kf, 1'b1, "kf kept after failed kickstart");
    clear_flags();
  endtask

  task automatic t_no_restart();
    wake_pulse();
    tick(1);
    wake_pulse();
    chk("R9", wf, 1'b1, "wf during sequence");
    tick(1);
    chk("R9", pwr_oe, 1'b0, "window not restarted by second wake");
    clear_flags();
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0;
    rst_n = 1'b0; sec_tick = 1'b0; wake_evt = 1'b0; ks_n = 1'b1; vcc_ok = 1'b0;
    osc_en = 1'b1; chain_rst = 1'b0; pab_wr = 1'b0; pab_wdata = 1'b0;
    wf_clr = 1'b0; kf_clr = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_wake_success();
    t_wake_fail();
    t_edge_success();
    t_freeze();
    t_kick();
    t_no_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule